// File: doc/BRIEF.md
# DDR3 Two-Rank Command Decoder and Bank Tracker

This block watches the command side of a two-rank DDR3 memory channel. On every rising clock edge it samples the per-rank chip selects and clock enables, the three command lines, the bank address and the address bus. It works out which command was issued and which ranks accept it, and turns that into one registered strobe per command class together with the target ranks, bank and address.

Inside, it keeps a model of every bank in every rank: whether a row is open and, if so, which row. This model lets it report the open row next to each read or write. It also flags accesses that break the open/closed rules. Each rank holds its own copy of the two mode-register fields that affect command handling. The first is the burst control (fixed length 8, fixed chop 4, or a choice made per command). The second is whether on-die termination is enabled, which gates that rank's termination request.

Every output is registered, so results appear one clock after the edge that sampled the command. Timing parameters, data capture and the physical layer are left to other blocks.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: The command is decoded from {ras_n, cas_n, we_n}: 000 mode-register load (o_mrs), 001 refresh (o_ref), 010 precharge (o_pre), 011 activate (o_act), 100 write (o_wr), 101 read (o_rd). Codes 110 and 111 raise no strobe. At most one strobe is high, registered one cycle after the sampling edge, with o_rank (bit r = rank r) and o_bank showing the target.
- R2: A rank accepts a command only when its cs_n bit is low and its cke bit is high at that edge. When no rank accepts, every strobe is low and o_rank is zero, and no bank state changes.
- R3: An activate opens bank ba of each accepting rank and records addr as its row; o_addr shows the row. A later read or write to that bank reports that row on o_row and the column addr[9:0], zero-extended, on o_addr.
- R4: A precharge with addr[10] low closes only bank ba. With addr[10] high it closes all eight banks of each accepting rank and raises o_all_banks.
- R5: A read or write with addr[10] high raises o_auto_pre and leaves the addressed bank closed afterwards.
- R6: A mode-register load with ba = 0 writes the burst control from addr[1:0]: 00 fixed length 8, 10 fixed chop 4, 01 or 11 chosen per command by addr[12] (0 chop 4, 1 length 8). A load with any other ba leaves the burst control unchanged. o_burst8 is 1 for length 8 on a read or write. o_addr carries the op-code and o_bank the register number. The burst control resets to 00.
- R7: A mode-register load with ba = 1 enables termination for that rank when any of addr[2], addr[6], addr[9] is set, and disables it otherwise. o_odt_en[r] is odt_in[r] AND that rank's enable, registered one cycle. Termination resets to disabled.
- R8: o_violation is raised one cycle after an accepted read or write to a closed bank, an activate to an open bank, or a refresh while any bank of an accepting rank is open.
- R9: Ranks are independent. A command accepted only by one rank changes no state of the other; with both chip selects low, both ranks act on it.
- R10: During and right after reset all strobes, o_rank, o_violation and o_odt_en are zero and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the command |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | NRANK | Active-low chip select per rank |
| cke | input | NRANK | Clock enable per rank |
| odt_in | input | NRANK | Termination request per rank |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| ba | input | BA_W | Bank address / mode register number |
| addr | input | ROW_W | Row, column, flag bits or op-code |
| o_mrs | output | 1 | Mode-register load strobe |
| o_ref | output | 1 | Refresh strobe |
| o_pre | output | 1 | Precharge strobe |
| o_act | output | 1 | Activate strobe |
| o_wr | output | 1 | Write strobe |
| o_rd | output | 1 | Read strobe |
| o_rank | output | NRANK | Ranks that accepted the command |
| o_bank | output | BA_W | Target bank or mode register |
| o_addr | output | ROW_W | Row, column or op-code |
| o_row | output | ROW_W | Open row of the accessed bank on read/write |
| o_all_banks | output | 1 | Precharge applies to every bank |
| o_auto_pre | output | 1 | Read/write requests auto-precharge |
| o_burst8 | output | 1 | 1 = burst length 8, 0 = chop 4 |
| o_odt_en | output | NRANK | Gated termination enable per rank |
| o_violation | output | 1 | Open/closed bank rule broken |

## Verification
Every result (strobes, rank, bank, address, row, burst, violation and termination enable) is due exactly one clock after the edge that sampled its input. The bench drives each command on a falling edge and samples two nanoseconds after the next rising edge, which is the first point where the registered outputs carry it. State effects such as a closed bank, an ignored command or a new burst mode are proved by a later command whose reported violation, row or burst exposes that state, again sampled one cycle after it is issued. The termination gate is observed one cycle after the request is driven, which is at the earliest one cycle after the mode-register load that changed it.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_RSV = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  // burst control field values (mode register 0, bits 1:0)
  localparam logic [1:0] BURST_FIX8 = 2'b00;
  localparam logic [1:0] BURST_FIX4 = 2'b10;

  // mode register numbers selected by the bank address
  localparam int MR_BURST = 0;
  localparam int MR_TERM  = 1;

  // termination field bit positions inside the op-code
  localparam int TERM_B0 = 2;
  localparam int TERM_B1 = 6;
  localparam int TERM_B2 = 9;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int COL_W  = 10
) (
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output cmd_e              cmd,
  output logic              is_cmd,
  output logic              is_rdwr,
  output logic [ADDR_W-1:0] col
);

  assign cmd     = cmd_e'({ras_n, cas_n, we_n});
  assign is_cmd  = (cmd != CMD_NOP) && (cmd != CMD_RSV);
  assign is_rdwr = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    col = '0;
    col[COL_W-1:0] = addr[COL_W-1:0];
  end

endmodule

// File: rtl/ddr_rank_state.sv
module ddr_rank_state
  import ddr_cmd_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 16,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  cmd_e              cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBANK-1:0]  open_vec,
  output logic [ADDR_W-1:0] row_rd,
  output logic              burst_long,
  output logic              rtt_on,
  output logic              viol
);

  logic [1:0]        bmode;
  logic [ADDR_W-1:0] rows [NBANK];
  logic              rdwr;

  assign rdwr = (cmd == CMD_RD) || (cmd == CMD_WR);

  // row store: no reset, write on activate only
  always_ff @(posedge clk) begin
    if (accept && cmd == CMD_ACT) rows[ba] <= addr;
  end

  assign row_rd = rows[ba];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vec <= '0;
      bmode    <= BURST_FIX8;
      rtt_on   <= 1'b0;
    end else if (accept) begin
      case (cmd)
        CMD_MRS: begin
          if (ba == BA_W'(MR_BURST)) bmode <= addr[1:0];
          if (ba == BA_W'(MR_TERM))
            rtt_on <= addr[TERM_B0] | addr[TERM_B1] | addr[TERM_B2];
        end
        CMD_PRE: begin
          if (addr[AP_BIT]) open_vec <= '0;
          else              open_vec[ba] <= 1'b0;
        end
        CMD_ACT: open_vec[ba] <= 1'b1;
        CMD_RD, CMD_WR: if (addr[AP_BIT]) open_vec[ba] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bmode)
      BURST_FIX8: burst_long = 1'b1;
      BURST_FIX4: burst_long = 1'b0;
      default:    burst_long = addr[BC_BIT];
    endcase
  end

  assign viol = accept && ((rdwr && !open_vec[ba]) ||
                           (cmd == CMD_ACT && open_vec[ba]) ||
                           (cmd == CMD_REF && (|open_vec)));

  // R4: precharge-all leaves the whole rank closed
  p_pre_all_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_PRE && addr[AP_BIT]) |=> (open_vec == '0));

  // R3: activate leaves the addressed bank open
  p_act_open_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_ACT) |=> open_vec[$past(ba)]);

  // R5: auto-precharge closes the accessed bank
  p_ap_close_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && rdwr && addr[AP_BIT]) |=> !open_vec[$past(ba)]);

  // R2: nothing accepted, nothing changes
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(open_vec));

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int NRANK  = 2,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRANK-1:0]  cs_n,
  input  logic [NRANK-1:0]  cke,
  input  logic [NRANK-1:0]  odt_in,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  output logic              o_mrs,
  output logic              o_ref,
  output logic              o_pre,
  output logic              o_act,
  output logic              o_wr,
  output logic              o_rd,
  output logic [NRANK-1:0]  o_rank,
  output logic [BA_W-1:0]   o_bank,
  output logic [ROW_W-1:0]  o_addr,
  output logic [ROW_W-1:0]  o_row,
  output logic              o_all_banks,
  output logic              o_auto_pre,
  output logic              o_burst8,
  output logic [NRANK-1:0]  o_odt_en,
  output logic              o_violation
);

  cmd_e             cmd;
  logic             is_cmd;
  logic             is_rdwr;
  logic [ROW_W-1:0] col;

  ddr_cmd_decode #(.ADDR_W(ROW_W), .COL_W(COL_W)) u_dec (
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .addr   (addr),
    .cmd    (cmd),
    .is_cmd (is_cmd),
    .is_rdwr(is_rdwr),
    .col    (col)
  );

  logic [NRANK-1:0] accept;
  logic [NRANK-1:0] rtt_vec;
  logic [NRANK-1:0] burst_vec;
  logic [NRANK-1:0] viol_vec;
  logic [ROW_W-1:0] row_arr [NRANK];

  assign accept = ~cs_n & cke & {NRANK{is_cmd}};

  for (genvar r = 0; r < NRANK; r++) begin : g_rank
    logic [NBANK-1:0] open_unused;
    ddr_rank_state #(
      .NBANK (NBANK),
      .ADDR_W(ROW_W),
      .AP_BIT(AP_BIT),
      .BC_BIT(BC_BIT)
    ) u_rank (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept[r]),
      .cmd       (cmd),
      .ba        (ba),
      .addr      (addr),
      .open_vec  (open_unused),
      .row_rd    (row_arr[r]),
      .burst_long(burst_vec[r]),
      .rtt_on    (rtt_vec[r]),
      .viol      (viol_vec[r])
    );
  end

  // lowest-numbered accepting rank supplies row and burst
  logic [ROW_W-1:0] sel_row;
  logic             sel_burst;
  always_comb begin
    sel_row   = '0;
    sel_burst = 1'b0;
    for (int r = NRANK - 1; r >= 0; r--) begin
      if (accept[r]) begin
        sel_row   = row_arr[r];
        sel_burst = burst_vec[r];
      end
    end
  end

  logic any;
  assign any = |accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_mrs       <= 1'b0;
      o_ref       <= 1'b0;
      o_pre       <= 1'b0;
      o_act       <= 1'b0;
      o_wr        <= 1'b0;
      o_rd        <= 1'b0;
      o_rank      <= '0;
      o_bank      <= '0;
      o_addr      <= '0;
      o_row       <= '0;
      o_all_banks <= 1'b0;
      o_auto_pre  <= 1'b0;
      o_burst8    <= 1'b0;
      o_odt_en    <= '0;
      o_violation <= 1'b0;
    end else begin
      o_mrs       <= any && cmd == CMD_MRS;
      o_ref       <= any && cmd == CMD_REF;
      o_pre       <= any && cmd == CMD_PRE;
      o_act       <= any && cmd == CMD_ACT;
      o_wr        <= any && cmd == CMD_WR;
      o_rd        <= any && cmd == CMD_RD;
      o_rank      <= accept;
      o_bank      <= any ? ba : '0;
      o_addr      <= !any ? '0 : (is_rdwr ? col : addr);
      o_row       <= (any && is_rdwr) ? sel_row : '0;
      o_all_banks <= any && cmd == CMD_PRE && addr[AP_BIT];
      o_auto_pre  <= any && is_rdwr && addr[AP_BIT];
      o_burst8    <= any && is_rdwr && sel_burst;
      o_odt_en    <= odt_in & rtt_vec;
      o_violation <= |viol_vec;
    end
  end

  // R1: never more than one command strobe
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({o_mrs, o_ref, o_pre, o_act, o_wr, o_rd}));

  // R2: all ranks deselected gives no command
  p_desel_r2: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |=> (o_rank == '0 && !o_mrs && !o_ref && !o_pre &&
                 !o_act && !o_wr && !o_rd));

  // R2: clock enable low on every rank gives no command
  p_cke_r2: assert property (@(posedge clk) disable iff (rst)
    (cke == '0) |=> (o_rank == '0));

  // R7: no termination request, no termination enable
  p_odt_r7: assert property (@(posedge clk) disable iff (rst)
    (odt_in == '0) |=> (o_odt_en == '0));

  // R6: burst type only accompanies reads and writes
  p_burst_r6: assert property (@(posedge clk) disable iff (rst)
    o_burst8 |-> (o_rd || o_wr));

  // R10: reset clears the reported state
  p_rst_r10: assert property (@(posedge clk)
    rst |=> (o_rank == '0 && !o_violation && o_odt_en == '0));

endmodule

// File: tb/ddr_cmd_tracker_bench.sv
module ddr_cmd_tracker_bench;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR  = 3'b100, C_RD  = 3'b101,
                         C_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cs_n = 2'b11, cke = 2'b11, odt_in = 2'b11;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [15:0] addr = '0;

  logic        o_mrs, o_ref, o_pre, o_act, o_wr, o_rd;
  logic [1:0]  o_rank, o_odt_en;
  logic [2:0]  o_bank;
  logic [15:0] o_addr, o_row;
  logic        o_all_banks, o_auto_pre, o_burst8, o_violation;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ddr_cmd_tracker u_ddr_cmd_tracker (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cke(cke), .odt_in(odt_in),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .o_mrs(o_mrs), .o_ref(o_ref), .o_pre(o_pre), .o_act(o_act),
    .o_wr(o_wr), .o_rd(o_rd), .o_rank(o_rank), .o_bank(o_bank),
    .o_addr(o_addr), .o_row(o_row), .o_all_banks(o_all_banks),
    .o_auto_pre(o_auto_pre), .o_burst8(o_burst8), .o_odt_en(o_odt_en),
    .o_violation(o_violation)
  );

  wire [5:0] strb = {o_mrs, o_ref, o_pre, o_act, o_wr, o_rd};

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns after the next rising edge
  task automatic issue(input logic [1:0] csn, input logic [1:0] ck,
                       input logic [2:0] c, input logic [2:0] b,
                       input logic [15:0] a);
    @(negedge clk);
    cs_n = csn; cke = ck; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] csel(input int r);
    return (r == 0) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [15:0] rowv(input int r, input int b);
    return 16'((r + 1) * 4096 + b * 273);
  endfunction

  function automatic logic [5:0] exp_strb(input int e);
    case (e)
      0: return 6'b100000;
      1: return 6'b010000;
      2: return 6'b001000;
      3: return 6'b000100;
      4: return 6'b000010;
      5: return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state, termination requested but disabled (R7)
    chk("R10 strobes", 32'(strb), 0);
    chk("R10 rank", 32'(o_rank), 0);
    chk("R10 violation", 32'(o_violation), 0);
    chk("R7 odt after reset", 32'(o_odt_en), 0);
    @(negedge clk); rst = 1'b0;

    // R1: decode sweep on rank 0
    for (int e = 0; e < 8; e++) begin
      issue(2'b10, 2'b11, 3'(e), 3'd0, 16'h0000);
      chk($sformatf("R1 strobe code %0d", e), 32'(strb), 32'(exp_strb(e)));
      chk($sformatf("R1 rank code %0d", e), 32'(o_rank),
          (exp_strb(e) != 0) ? 1 : 0);
      chk($sformatf("R8 no viol code %0d", e), 32'(o_violation), 0);
    end
    issue(2'b10, 2'b11, C_PRE, 3'd0, 16'h0400);

    // R3: activate all banks of both ranks
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++) begin
        issue(csel(r), 2'b11, C_ACT, 3'(b), rowv(r, b));
        chk("R3 act strobe", 32'(o_act), 1);
        chk("R3 act rank", 32'(o_rank), 32'(1 << r));
        chk("R3 act bank", 32'(o_bank), b);
        chk("R3 act row", 32'(o_addr), 32'(rowv(r, b)));
        chk("R8 act closed bank", 32'(o_violation), 0);
      end
    // R3/R6: reads report row, column, fixed length 8
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++) begin
        issue(csel(r), 2'b11, C_RD, 3'(b), 16'(16'h1000 | (b * 16 + r)));
        chk("R3 rd strobe", 32'(o_rd), 1);
        chk("R3 rd row", 32'(o_row), 32'(rowv(r, b)));
        chk("R3 rd col", 32'(o_addr), b * 16 + r);
        chk("R6 fixed burst8", 32'(o_burst8), 1);
        chk("R5 no auto pre", 32'(o_auto_pre), 0);
        chk("R8 rd open bank", 32'(o_violation), 0);
      end

    // R8: activate open bank, refresh with open banks
    issue(2'b10, 2'b11, C_ACT, 3'd2, 16'h0123);
    chk("R8 act open bank", 32'(o_violation), 1);
    issue(2'b01, 2'b11, C_REF, 3'd0, 16'h0000);
    chk("R8 ref strobe", 32'(o_ref), 1);
    chk("R8 ref with open", 32'(o_violation), 1);

    // R4: single-bank precharge
    issue(2'b10, 2'b11, C_PRE, 3'd3, 16'h0000);
    chk("R4 pre strobe", 32'(o_pre), 1);
    chk("R4 single flag", 32'(o_all_banks), 0);
    issue(2'b10, 2'b11, C_RD, 3'd3, 16'h0000);
    chk("R4 closed bank read", 32'(o_violation), 1);
    issue(2'b10, 2'b11, C_RD, 3'd4, 16'h0000);
    chk("R4 neighbour stays open", 32'(o_violation), 0);

    // R4: precharge all on rank 1
    issue(2'b01, 2'b11, C_PRE, 3'd5, 16'h0400);
    chk("R4 all flag", 32'(o_all_banks), 1);
    for (int b = 0; b < 8; b++) begin
      issue(2'b01, 2'b11, C_RD, 3'(b), 16'h0000);
      chk("R4 rank1 closed", 32'(o_violation), 1);
    end
    // R9: rank 0 untouched
    issue(2'b10, 2'b11, C_RD, 3'd5, 16'h0000);
    chk("R9 rank0 open", 32'(o_violation), 0);
    chk("R9 rank0 row", 32'(o_row), 32'(rowv(0, 5)));

    // R5: write with auto-precharge
    issue(2'b10, 2'b11, C_WR, 3'd2, 16'h0407);
    chk("R5 wr strobe", 32'(o_wr), 1);
    chk("R5 auto pre", 32'(o_auto_pre), 1);
    chk("R5 wr col", 32'(o_addr), 7);
    chk("R5 wr viol", 32'(o_violation), 0);
    issue(2'b10, 2'b11, C_RD, 3'd2, 16'h0000);
    chk("R5 bank closed after", 32'(o_violation), 1);
    issue(2'b10, 2'b11, C_ACT, 3'd2, 16'h0077);
    chk("R5 reopen ok", 32'(o_violation), 0);

    // R2: clock enable low ignores the command
    issue(2'b10, 2'b10, C_ACT, 3'd3, 16'h0055);
    chk("R2 cke rank", 32'(o_rank), 0);
    chk("R2 cke strobe", 32'(strb), 0);
    issue(2'b10, 2'b11, C_RD, 3'd3, 16'h0000);
    chk("R2 cke bank still closed", 32'(o_violation), 1);
    // R2: deselect ignores the command
    issue(2'b11, 2'b11, C_ACT, 3'd3, 16'h0055);
    chk("R2 desel strobe", 32'(strb), 0);
    chk("R2 desel rank", 32'(o_rank), 0);
    issue(2'b10, 2'b11, C_RD, 3'd3, 16'h0000);
    chk("R2 desel bank still closed", 32'(o_violation), 1);

    // R9: both ranks selected
    issue(2'b00, 2'b11, C_ACT, 3'd6, 16'h0abc);
    chk("R9 both rank", 32'(o_rank), 3);
    chk("R9 rank0 bank6 open", 32'(o_violation), 1);
    issue(2'b01, 2'b11, C_RD, 3'd6, 16'h0000);
    chk("R9 rank1 opened", 32'(o_violation), 0);
    chk("R9 rank1 row", 32'(o_row), 16'h0abc);
    issue(2'b00, 2'b11, C_PRE, 3'd0, 16'h0400);
    chk("R4 both all", 32'(o_rank), 3);
    issue(2'b00, 2'b11, C_REF, 3'd0, 16'h0000);
    chk("R8 ref all closed", 32'(o_violation), 0);

    // R6: burst modes
    issue(2'b10, 2'b11, C_MRS, 3'd0, 16'h0002);
    chk("R6 mrs strobe", 32'(o_mrs), 1);
    chk("R6 mrs bank", 32'(o_bank), 0);
    chk("R6 mrs opcode", 32'(o_addr), 2);
    issue(2'b10, 2'b11, C_ACT, 3'd1, 16'h0055);
    issue(2'b10, 2'b11, C_RD, 3'd1, 16'h1000);
    chk("R6 fixed chop", 32'(o_burst8), 0);
    issue(2'b10, 2'b11, C_MRS, 3'd0, 16'h0001);
    issue(2'b10, 2'b11, C_RD, 3'd1, 16'h0000);
    chk("R6 otf a12 low", 32'(o_burst8), 0);
    issue(2'b10, 2'b11, C_WR, 3'd1, 16'h1000);
    chk("R6 otf a12 high", 32'(o_burst8), 1);
    issue(2'b10, 2'b11, C_MRS, 3'd2, 16'h0002);
    issue(2'b10, 2'b11, C_RD, 3'd1, 16'h1000);
    chk("R6 other mr keeps burst", 32'(o_burst8), 1);
    issue(2'b01, 2'b11, C_ACT, 3'd1, 16'h0066);
    issue(2'b01, 2'b11, C_RD, 3'd1, 16'h0000);
    chk("R9 rank1 still fixed8", 32'(o_burst8), 1);

    // R7: termination gating
    issue(2'b10, 2'b11, C_MRS, 3'd1, 16'h0040);
    issue(2'b11, 2'b11, C_NOP, 3'd0, 16'h0000);
    chk("R7 rank0 enabled", 32'(o_odt_en), 1);
    @(negedge clk); odt_in = 2'b10;
    issue(2'b11, 2'b11, C_NOP, 3'd0, 16'h0000);
    chk("R7 rank1 disabled", 32'(o_odt_en), 0);
    issue(2'b01, 2'b11, C_MRS, 3'd1, 16'h0004);
    @(negedge clk); odt_in = 2'b11;
    issue(2'b11, 2'b11, C_NOP, 3'd0, 16'h0000);
    chk("R7 both enabled", 32'(o_odt_en), 3);
    issue(2'b10, 2'b11, C_MRS, 3'd1, 16'h0000);
    issue(2'b11, 2'b11, C_NOP, 3'd0, 16'h0000);
    chk("R7 rank0 disabled again", 32'(o_odt_en), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule